// File: doc/BRIEF.md
# Parallel Flash Bus Bridge

This block turns single requests from an internal master (byte address, read or write, byte or halfword size, write data, valid/ready) into timed cycles on an asynchronous parallel flash bus. The bus side carries a 25-bit address, a 16-bit data path with a separate drive enable, an active-low read strobe, an active-low write strobe and two active-low chip selects. Each request completes with a one-cycle response that carries read data or an error flag.

There are two address windows, one for each chip select. Each window has its own enable, base, power-of-two size, device width (8 or 16 bits) and two 4-bit wait counts. One count sets how long the strobe stays low. The other sets how long the bus stays idle afterwards. Window 0 leaves reset enabled with both waits at their maximum and its width taken from a strap pin, so an unconfigured boot device can be fetched from. A separate write port replaces the settings of one window. A request uses the settings that are in place when it is accepted.

A halfword read on an 8-bit window becomes two device cycles, low byte first. A write must fit in a single device cycle. A write that does not fit, a misaligned halfword on a 16-bit window, or an address outside both enabled windows is answered with an error and drives no strobe.

Top module: `pflash_bridge`

## Requirements
- R1: With `rst` high at a clock edge, window 0 becomes enabled, with base 0, size 2^24 bytes, both waits 15 and width 16 bits if `strap_wide` is 1, else 8 bits. Window 1 becomes disabled, with base 0x1000000, size 2^20, both waits 15 and width 8. After reset `req_ready` is 1, all strobes and chip selects are high and `rsp_valid` is 0.
- R2: `fce_n[n]` goes low only for a request that hits window n. A hit means the window is enabled and `addr[24:s] == base[24:s]`, where s is the window's size field. If both windows match, window 0 wins. At most one chip select is low at any time.
- R3: After acceptance, one setup cycle has the chip select low and both strobes high. The strobe then stays low for a2d+1 cycles, and read data is captured on the last of these.
- R4: After the last strobe cycle, all chip selects are high and `req_ready` is low for rec cycles. `rsp_valid` pulses for one cycle, on the first of those cycles, or on the first ready cycle when rec is 0.
- R5: On a 16-bit window, a byte read returns the data lane chosen by `addr[0]` (0 gives `fd_i[7:0]`, 1 gives `fd_i[15:8]`) in `rsp_rdata[7:0]`, with the upper byte zero. A halfword read returns `fd_i`. On an 8-bit window, a byte read returns `fd_i[7:0]`.
- R6: A halfword read on an 8-bit window makes two device cycles, at `fa = addr` and then `addr+1`, with rec idle cycles between them. The result is {second byte, first byte}.
- R7: A write uses `fwe_n` and never `foe_n`, and holds `fd_drive` high while its strobe is low. `fd_o` carries the write data for a halfword, or the byte copied onto both lanes for a byte.
- R8: A halfword write to an 8-bit window is answered with `rsp_err` = 1 in the cycle after acceptance, and no chip select or strobe goes low.
- R9: A halfword access with `addr[0]` = 1 on a 16-bit window is answered with an error and drives no strobe.
- R10: A request that hits no enabled window is answered with an error in the cycle after acceptance and drives no strobe or chip select.
- R11: A `cfg_we` pulse replaces all fields of the window selected by `cfg_sel`. An access already accepted keeps the wait counts it started with.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| strap_wide | input | 1 | Boot width strap for window 0 (1 = 16-bit) |
| cfg_we | input | 1 | Write strobe for the window settings |
| cfg_sel | input | 1 | Window index to write |
| cfg_en | input | 1 | New enable |
| cfg_wide | input | 1 | New width (1 = 16-bit) |
| cfg_a2d | input | 4 | New strobe wait count |
| cfg_rec | input | 4 | New recovery wait count |
| cfg_base | input | 25 | New window base |
| cfg_size | input | 5 | New window size as log2 of bytes |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Bridge can accept a request |
| req_addr | input | 25 | Byte address |
| req_write | input | 1 | 1 = write |
| req_half | input | 1 | 1 = halfword, 0 = byte |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Request rejected |
| rsp_rdata | output | 16 | Read data |
| fa | output | 25 | Flash address |
| fd_o | output | 16 | Flash write data |
| fd_i | input | 16 | Flash read data |
| fd_drive | output | 1 | Drive enable for `fd_o` |
| foe_n | output | 1 | Read strobe, active low |
| fwe_n | output | 1 | Write strobe, active low |
| fce_n | output | 2 | Chip selects, active low, one per window |

## Verification
A flash model returns a data word made from the address, so a wrong lane, a wrong byte order or a wrong beat address shows up as a wrong value. A vector table sends byte and halfword reads and writes to both windows, with different widths and wait counts. Each access measures strobe length, recovery length, the chip select used and the data. This tells width handling, splitting and per-window timing apart. Directed cases cover the boot defaults under both strap values, addresses just inside and just outside a window, the three rejection causes, a recovery count of zero, and a settings change made while an access is in flight.

// File: rtl/pflash_pkg.sv
package pflash_pkg;
    localparam int ADDR_W      = 25;
    localparam int DATA_W      = 16;
    localparam int BYTE_W      = 8;
    localparam int WAIT_W      = 4;
    localparam int SIZE_W      = 5;
    localparam int NUM_WIN     = 2;
    localparam int IDX_W       = $clog2(NUM_WIN);
    localparam int SPAN_LOG    = 24;
    localparam int BOOT_SIZE   = 24;
    localparam int OTHER_SIZE  = 20;

    typedef struct packed {
        logic              en;
        logic              wide;
        logic [WAIT_W-1:0] a2d;
        logic [WAIT_W-1:0] rec;
        logic [ADDR_W-1:0] base;
        logic [SIZE_W-1:0] size;
    } win_cfg_t;

    typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_STROBE, ST_RECOVER} seq_st_t;

    function automatic logic addr_match(logic en, logic [ADDR_W-1:0] base,
                                        logic [SIZE_W-1:0] size, logic [ADDR_W-1:0] a);
        logic [ADDR_W-1:0] mask;
        mask = (int'(size) >= ADDR_W) ? '0 : ({ADDR_W{1'b1}} << size);
        return en && ((a & mask) == (base & mask));
    endfunction

    function automatic win_cfg_t boot_cfg(int idx, logic strap);
        win_cfg_t c;
        c.en   = (idx == 0);
        c.wide = (idx == 0) ? strap : 1'b0;
        c.a2d  = '1;
        c.rec  = '1;
        c.base = ADDR_W'(idx) << SPAN_LOG;
        c.size = (idx == 0) ? SIZE_W'(BOOT_SIZE) : SIZE_W'(OTHER_SIZE);
        return c;
    endfunction
endpackage

// File: rtl/pflash_cfg.sv
module pflash_cfg
    import pflash_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             strap_wide,
    input  logic             cfg_we,
    input  logic [IDX_W-1:0] cfg_sel,
    input  win_cfg_t         cfg_wdata,
    output win_cfg_t         win_q [NUM_WIN]
);
    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_WIN; i++) begin
            if (rst)
                win_q[i] <= boot_cfg(i, strap_wide);
            else if (cfg_we && cfg_sel == IDX_W'(i))
                win_q[i] <= cfg_wdata;
        end
    end

    AST_BOOT_DEFAULT: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && !$past(cfg_we)) |-> (win_q[0].en && win_q[0].a2d == '1 && win_q[0].rec == '1
                          && win_q[0].wide == $past(strap_wide) && !win_q[1].en)); // R1
endmodule

// File: rtl/pflash_dec.sv
module pflash_dec
    import pflash_pkg::*;
(
    input  win_cfg_t          win [NUM_WIN],
    input  logic [ADDR_W-1:0] addr,
    input  logic              write,
    input  logic              half,
    output logic [IDX_W-1:0]  idx,
    output logic              err,
    output logic              wide,
    output logic [WAIT_W-1:0] a2d,
    output logic [WAIT_W-1:0] rec
);
    logic hit;

    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (addr_match(win[i].en, win[i].base, win[i].size, addr)) begin
                hit = 1'b1;
                idx = IDX_W'(i);
            end
        end
        wide = win[idx].wide;
        a2d  = win[idx].a2d;
        rec  = win[idx].rec;
        err  = !hit
            || (half && write && !wide)
            || (half && wide && addr[0]);
    end
endmodule

// File: rtl/pflash_seq.sv
module pflash_seq
    import pflash_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic              req_half,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [IDX_W-1:0]  dec_idx,
    input  logic              dec_err,
    input  logic              dec_wide,
    input  logic [WAIT_W-1:0] dec_a2d,
    input  logic [WAIT_W-1:0] dec_rec,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] fa,
    output logic [DATA_W-1:0] fd_o,
    input  logic [DATA_W-1:0] fd_i,
    output logic              fd_drive,
    output logic              foe_n,
    output logic              fwe_n,
    output logic [NUM_WIN-1:0] fce_n
);
    seq_st_t           st;
    logic [WAIT_W-1:0] cnt, a2d_q, rec_q;
    logic [IDX_W-1:0]  idx_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q, rd_next;
    logic [BYTE_W-1:0] lo_q, lane;
    logic              wide_q, write_q, half_q, split_q, beat_q, more_q, accept, last_beat, bus_on;

    assign req_ready = (st == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign last_beat = !split_q || beat_q;
    assign bus_on    = (st == ST_SETUP) || (st == ST_STROBE);

    always_comb begin
        lane = (wide_q && addr_q[0]) ? fd_i[DATA_W-1:BYTE_W] : fd_i[BYTE_W-1:0];
        if (write_q)             rd_next = '0;
        else if (half_q && wide_q) rd_next = fd_i;
        else if (split_q && beat_q) rd_next = {lane, lo_q};
        else                     rd_next = {{(DATA_W-BYTE_W){1'b0}}, lane};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= ST_IDLE;   cnt <= '0;     a2d_q <= '0;  rec_q <= '0;  idx_q <= '0;
            addr_q <= '0;    wdata_q <= '0; lo_q <= '0;   wide_q <= 1'b0;
            write_q <= 1'b0; half_q <= 1'b0; split_q <= 1'b0; beat_q <= 1'b0; more_q <= 1'b0;
            rsp_valid <= 1'b0; rsp_err <= 1'b0; rsp_rdata <= '0;
        end else begin
            rsp_valid <= 1'b0;
            unique case (st)
                ST_IDLE: if (accept) begin
                    if (dec_err) begin
                        rsp_valid <= 1'b1;
                        rsp_err   <= 1'b1;
                        rsp_rdata <= '0;
                    end else begin
                        st      <= ST_SETUP;
                        a2d_q   <= dec_a2d;
                        rec_q   <= dec_rec;
                        idx_q   <= dec_idx;
                        wide_q  <= dec_wide;
                        addr_q  <= req_addr;
                        write_q <= req_write;
                        half_q  <= req_half;
                        wdata_q <= req_wdata;
                        split_q <= req_half && !dec_wide && !req_write;
                        beat_q  <= 1'b0;
                    end
                end
                ST_SETUP: begin
                    st  <= ST_STROBE;
                    cnt <= a2d_q;
                end
                ST_STROBE: begin
                    if (cnt != '0) begin
                        cnt <= cnt - 1'b1;
                    end else begin
                        lo_q   <= rd_next[BYTE_W-1:0];
                        more_q <= !last_beat;
                        if (last_beat) begin
                            rsp_valid <= 1'b1;
                            rsp_err   <= 1'b0;
                            rsp_rdata <= rd_next;
                        end else begin
                            beat_q <= 1'b1;
                            addr_q <= addr_q + ADDR_W'(1);
                        end
                        if (rec_q != '0) begin
                            st  <= ST_RECOVER;
                            cnt <= rec_q - 1'b1;
                        end else begin
                            st <= last_beat ? ST_IDLE : ST_SETUP;
                        end
                    end
                end
                ST_RECOVER: begin
                    if (cnt != '0) cnt <= cnt - 1'b1;
                    else           st  <= more_q ? ST_SETUP : ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign fa       = addr_q;
    assign fd_o     = half_q ? wdata_q : {2{wdata_q[BYTE_W-1:0]}};
    assign fd_drive = write_q && bus_on;
    assign foe_n    = !((st == ST_STROBE) && !write_q);
    assign fwe_n    = !((st == ST_STROBE) && write_q);

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_ce
        assign fce_n[g] = !(bus_on && idx_q == IDX_W'(g));
    end

    AST_ONE_CE: assert property (@(posedge clk) disable iff (rst)
        $countones(~fce_n) <= 1); // R2
    AST_STROBE_UNDER_CE: assert property (@(posedge clk) disable iff (rst)
        (!foe_n || !fwe_n) |-> (fce_n != '1)); // R3
    AST_SETUP_FIRST: assert property (@(posedge clk) disable iff (rst)
        ($fell(foe_n) || $fell(fwe_n)) |-> ($past(fce_n) == fce_n)); // R3
    AST_IDLE_IN_RECOVERY: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RECOVER) |-> (fce_n == '1 && !req_ready)); // R4
    AST_WRITE_DRIVES: assert property (@(posedge clk) disable iff (rst)
        !fwe_n |-> (fd_drive && foe_n)); // R7
    AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (rst)
        (accept && dec_err) |=> (foe_n && fwe_n && fce_n == '1 && rsp_valid && rsp_err)); // R10
endmodule

// File: rtl/pflash_bridge.sv
module pflash_bridge
    import pflash_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        strap_wide,
    input  logic        cfg_we,
    input  logic [0:0]  cfg_sel,
    input  logic        cfg_en,
    input  logic        cfg_wide,
    input  logic [3:0]  cfg_a2d,
    input  logic [3:0]  cfg_rec,
    input  logic [24:0] cfg_base,
    input  logic [4:0]  cfg_size,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [24:0] req_addr,
    input  logic        req_write,
    input  logic        req_half,
    input  logic [15:0] req_wdata,
    output logic        rsp_valid,
    output logic        rsp_err,
    output logic [15:0] rsp_rdata,
    output logic [24:0] fa,
    output logic [15:0] fd_o,
    input  logic [15:0] fd_i,
    output logic        fd_drive,
    output logic        foe_n,
    output logic        fwe_n,
    output logic [1:0]  fce_n
);
    win_cfg_t          win_q [NUM_WIN];
    win_cfg_t          cfg_word;
    logic [IDX_W-1:0]  dec_idx;
    logic              dec_err, dec_wide;
    logic [WAIT_W-1:0] dec_a2d, dec_rec;

    assign cfg_word = '{en: cfg_en, wide: cfg_wide, a2d: cfg_a2d, rec: cfg_rec,
                        base: cfg_base, size: cfg_size};

    pflash_cfg u_cfg (
        .clk(clk), .rst(rst), .strap_wide(strap_wide), .cfg_we(cfg_we),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_word), .win_q(win_q)
    );

    pflash_dec u_dec (
        .win(win_q), .addr(req_addr), .write(req_write), .half(req_half),
        .idx(dec_idx), .err(dec_err), .wide(dec_wide), .a2d(dec_a2d), .rec(dec_rec)
    );

    pflash_seq u_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_write(req_write), .req_half(req_half), .req_wdata(req_wdata),
        .dec_idx(dec_idx), .dec_err(dec_err), .dec_wide(dec_wide), .dec_a2d(dec_a2d),
        .dec_rec(dec_rec), .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .fa(fa), .fd_o(fd_o), .fd_i(fd_i), .fd_drive(fd_drive), .foe_n(foe_n),
        .fwe_n(fwe_n), .fce_n(fce_n)
    );
endmodule

// File: tb/pflash_bridge_bench.sv
`timescale 1ns/1ps
module pflash_bridge_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1, strap_wide = 1'b1;
    logic        cfg_we = 1'b0, cfg_en = 1'b0, cfg_wide = 1'b0;
    logic [0:0]  cfg_sel = '0;
    logic [3:0]  cfg_a2d = '0, cfg_rec = '0;
    logic [24:0] cfg_base = '0;
    logic [4:0]  cfg_size = '0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_half = 1'b0;
    logic [24:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        req_ready, rsp_valid, rsp_err, fd_drive, foe_n, fwe_n;
    logic [15:0] rsp_rdata, fd_o, fd_i;
    logic [24:0] fa;
    logic [1:0]  fce_n;
    int n_chk = 0, n_bad = 0;
    int a2d_of [2];
    int rec_of [2];

    always #2 clk = ~clk;

    assign fd_i = {fa[7:0] ^ 8'hA5, fa[7:0]};

    pflash_bridge u_pflash_bridge (.*);

    typedef struct packed {
        int          strobes, beats, rec;
        logic        err, wr, drive, hung;
        logic [1:0]  ce_low;
        logic [15:0] rdata, fdo;
        logic [24:0] fa0, fa1;
    } result_t;

    typedef struct packed {
        logic [24:0] addr;
        logic        w, h;
        logic [15:0] d;
        logic        err;
        logic        win;
        logic [15:0] exp;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{25'h0000100, 1'b0, 1'b1, 16'h0000, 1'b0, 1'b0, 16'hA500},
        '{25'h0000103, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 16'h00A6},
        '{25'h0000102, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 16'h0002},
        '{25'h0000103, 1'b0, 1'b1, 16'h0000, 1'b1, 1'b0, 16'h0000},
        '{25'h1000010, 1'b0, 1'b1, 16'h0000, 1'b0, 1'b1, 16'h1110},
        '{25'h1000022, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b1, 16'h0022},
        '{25'h1000005, 1'b1, 1'b0, 16'h12C3, 1'b0, 1'b1, 16'hC3C3},
        '{25'h1000006, 1'b1, 1'b1, 16'h5678, 1'b1, 1'b1, 16'h0000},
        '{25'h0000010, 1'b1, 1'b1, 16'hBEEF, 1'b0, 1'b0, 16'hBEEF},
        '{25'h1800000, 1'b0, 1'b0, 16'h0000, 1'b1, 1'b1, 16'h0000},
        '{25'h10FFFFF, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b1, 16'h00FF},
        '{25'h1100000, 1'b0, 1'b0, 16'h0000, 1'b1, 1'b1, 16'h0000}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic strap);
        @(negedge clk);
        strap_wide = strap;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        a2d_of = '{15, 15};
        rec_of = '{15, 15};
    endtask

    task automatic cfg_write(input int sel, input logic en, wide, input int a2d, rec,
                             input logic [24:0] base, input logic [4:0] size);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 1'(sel); cfg_en = en; cfg_wide = wide;
        cfg_a2d = 4'(a2d); cfg_rec = 4'(rec); cfg_base = base; cfg_size = size;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic run_access(input logic [24:0] a, input logic w, h, input logic [15:0] d,
                              output result_t r);
        int guard = 0;
        logic prev = 1'b0, strobe;
        r = '0;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_write = w; req_half = h; req_wdata = d;
        while (!req_ready && guard < 400) begin @(negedge clk); guard++; end
        @(negedge clk);
        req_valid = 1'b0;
        while (!rsp_valid && guard < 400) begin
            strobe = !foe_n || !fwe_n;
            if (strobe) begin
                r.strobes++;
                if (!prev) begin
                    r.beats++;
                    if (r.beats == 1) r.fa0 = fa; else r.fa1 = fa;
                end
                r.ce_low = ~fce_n;
                r.wr     = !fwe_n;
                r.drive  = fd_drive;
                r.fdo    = fd_o;
            end
            prev = strobe;
            @(negedge clk); guard++;
        end
        r.err   = rsp_err;
        r.rdata = rsp_rdata;
        while (!req_ready && guard < 400) begin r.rec++; @(negedge clk); guard++; end
        r.hung = (guard >= 400);
    endtask

    initial begin
        #(4 * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        result_t r;
        do_reset(1'b1);
        @(negedge clk);
        // R1: state right after reset
        chk(req_ready === 1'b1, "R1 ready", int'(req_ready), 1);
        chk(fce_n === 2'b11 && foe_n === 1'b1 && fwe_n === 1'b1, "R1 bus idle",
            int'({fce_n, foe_n, fwe_n}), 'hF);
        chk(rsp_valid === 1'b0, "R1 no rsp", int'(rsp_valid), 0);

        // R1: boot window 0, max waits, 16-bit from strap; odd byte lane
        run_access(25'h0000001, 1'b0, 1'b0, 16'h0, r);
        chk(r.strobes == 16, "R1 boot strobe", r.strobes, 16);
        chk(r.rec == 15, "R1 boot recovery", r.rec, 15);
        chk(r.rdata == 16'h00A4, "R1 R5 boot lane", int'(r.rdata), 'hA4);
        chk(r.ce_low == 2'b01, "R1 boot uses ce0", int'(r.ce_low), 1);
        // R1/R10: window 1 disabled after reset
        run_access(25'h1000000, 1'b0, 1'b0, 16'h0, r);
        chk(r.err && r.strobes == 0 && r.ce_low == 2'b00, "R10 disabled window", int'(r.err), 1);

        cfg_write(0, 1'b1, 1'b1, 2, 1, 25'h0, 5'd24);
        cfg_write(1, 1'b1, 1'b0, 1, 3, 25'h1000000, 5'd20);
        a2d_of = '{2, 1};
        rec_of = '{1, 3};

        for (int i = 0; i < NV; i++) begin
            vec_t v = VECS[i];
            int beats = (v.h && !v.w && v.win) ? 2 : 1;
            run_access(v.addr, v.w, v.h, v.d, r);
            chk(!r.hung, "R4 completes", int'(r.hung), 0);
            chk(r.err == v.err, v.w ? "R8 R9 R10 err flag" : "R9 R10 err flag", int'(r.err), int'(v.err));
            if (v.err) begin
                chk(r.strobes == 0 && r.ce_low == 2'b00, "R8 R9 no strobe", r.strobes, 0);
            end else begin
                chk(r.ce_low == (v.win ? 2'b10 : 2'b01), "R2 chip select", int'(r.ce_low),
                    v.win ? 2 : 1);
                chk(r.beats == beats, "R6 beat count", r.beats, beats);
                chk(r.strobes == beats * (a2d_of[v.win] + 1), "R3 strobe length", r.strobes,
                    beats * (a2d_of[v.win] + 1));
                chk(r.rec == rec_of[v.win], "R4 recovery", r.rec, rec_of[v.win]);
                chk(r.fa0 == v.addr, "R6 first address", int'(r.fa0), int'(v.addr));
                if (beats == 2)
                    chk(r.fa1 == v.addr + 25'd1, "R6 second address", int'(r.fa1), int'(v.addr + 25'd1));
                if (v.w) begin
                    chk(r.wr && r.drive, "R7 write strobe", int'({r.wr, r.drive}), 3);
                    chk(r.fdo == v.exp, "R7 write data", int'(r.fdo), int'(v.exp));
                end else begin
                    chk(!r.wr, "R7 read uses oe", int'(r.wr), 0);
                    chk(r.rdata == v.exp, "R5 R6 read data", int'(r.rdata), int'(v.exp));
                end
            end
        end

        // R11: settings changed mid-access apply only to later accesses
        fork
            run_access(25'h1000000, 1'b0, 1'b0, 16'h0, r);
            begin
                repeat (3) @(negedge clk);
                cfg_write(1, 1'b1, 1'b0, 5, 3, 25'h1000000, 5'd20);
            end
        join
        chk(r.strobes == 2, "R11 in-flight keeps waits", r.strobes, 2);
        run_access(25'h1000000, 1'b0, 1'b0, 16'h0, r);
        chk(r.strobes == 6, "R11 new waits applied", r.strobes, 6);

        // R4: zero recovery
        cfg_write(1, 1'b1, 1'b0, 1, 0, 25'h1000000, 5'd20);
        run_access(25'h1000001, 1'b0, 1'b0, 16'h0, r);
        chk(r.rec == 0 && !r.err, "R4 zero recovery", r.rec, 0);
        chk(r.rdata == 16'h0001, "R4 zero recovery data", int'(r.rdata), 1);

        // R1/R6/R8: strap low gives an 8-bit boot window
        do_reset(1'b0);
        run_access(25'h0000020, 1'b0, 1'b1, 16'h0, r);
        chk(r.beats == 2 && r.strobes == 32, "R1 R6 narrow boot split", r.strobes, 32);
        chk(r.rdata == 16'h2120, "R6 byte order", int'(r.rdata), 'h2120);
        run_access(25'h0000020, 1'b1, 1'b1, 16'hABCD, r);
        chk(r.err && r.strobes == 0, "R8 halfword write to narrow", int'(r.err), 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule